// File: doc/BRIEF.md
# Tagged Index-Register Address Unit

This unit forms the effective address of an instruction on a 36-bit word machine. It takes the instruction word and pulls out three fields: a 15-bit address field Y, a 3-bit tag and a 2-bit flag. It subtracts an index contribution chosen by the tag from Y, and the result wraps modulo 2^15. It holds seven 15-bit index registers, which are loaded through a write port. A mode bit chooses one of two indexing schemes. In the grouped scheme, the registers named by the tag bits are OR-ed together. In the numbered scheme, the tag value picks one register.

When both flag bits are set, the first result is an indirect pointer. The unit reads that word through a request/response memory port. It then indexes the fetched word's own Y and tag to produce the final address. A separate input marks instructions that manipulate index registers; for those the address is Y unchanged. A one-cycle done strobe and the address come out one cycle after the last indexing step.

Bit positions follow left-to-right numbering, with S as bit 0 and bit 35 as the rightmost bit. In the 36-bit vector `[35:0]`, document bit k sits at vector index 35-k.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done` and `mem_req` are 0, the unit is in grouped mode, and all index registers are zero.
- R2: A direct instruction (flag not 11, `idx_ctl`=0) accepted on a `start` edge yields `done`=1 and `ea` = Y − C(T) in the next cycle. Y is `instr[14:0]`, the tag is `instr[17:15]` and the flag is `instr[23:22]`. A tag of 0 gives C(T)=0.
- R3: In grouped mode, C(T) is the OR of the selected registers. Tag bit value 1 (`instr[15]`) selects register 1 (A), value 2 selects register 2 (B), and value 4 selects register 4 (C).
- R4: In grouped mode, a load (`ld_en`) writes `ld_data` into every one of A, B and C whose bit is set in `ld_tag`. The new value is used from the next cycle.
- R5: After a `lmtm` pulse, the unit is in numbered mode. A nonzero tag t selects register t for both reading and loading.
- R6: In grouped mode, registers 3, 5, 6 and 7 are never written. After leaving grouped mode they still read zero until they are loaded.
- R7: The subtraction Y − C(T) wraps modulo 2^15.
- R8: With `idx_ctl`=1, `ea` = Y with no indexing, and no memory request is made, whatever the flag holds.
- R9: Flag 11 with `idx_ctl`=0 raises `mem_req` one cycle after `start`, with `mem_addr` = Y − C(T). The request holds steady until `mem_rvalid`. One cycle after `mem_rvalid`, `done`=1 and `ea` is the fetched word's Y − C(its tag); the fetched word's flag is ignored.
- R10: Flag values 01 and 10 are direct addressing.
- R11: `start` is ignored while a fetch is pending, and `mem_rvalid` is ignored when no request is outstanding.
- R12: Indexing in a cycle that also loads a register uses the register value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address formation for `instr` |
| instr | input | 36 | Instruction word |
| idx_ctl | input | 1 | Instruction is an index-register control type |
| ld_en | input | 1 | Index register load strobe |
| ld_tag | input | 3 | Tag selecting registers to load |
| ld_data | input | 15 | Load value |
| lmtm | input | 1 | Leave grouped mode |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 15 | Indirect word address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 36 | Fetched indirect word |
| done | output | 1 | One-cycle result strobe |
| ea | output | 15 | Effective address |

## Verification
Direct and control results are due one cycle after the `start` edge. The bench samples `done` and `ea` at the falling edge that follows the capturing rising edge. For an indirect fetch, `mem_req` and `mem_addr` are due one cycle after `start`, and the final address one cycle after the `mem_rvalid` edge. The driver checks each strobe at exactly that falling edge. The expected addresses go into a queue, and a falling-edge monitor pops one entry per `done`. That way an early, late or extra strobe shows up as a mismatch or as an unexpected pop.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W    = 36;
    localparam int ADDR_W    = 15;
    localparam int TAG_W     = 3;
    localparam int FLAG_W    = 2;
    localparam int Y_LSB     = 0;
    localparam int TAG_LSB   = Y_LSB + ADDR_W;
    localparam int FLAG_LSB  = 22;
    localparam int NUM_IDX   = (1 << TAG_W) - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [FLAG_W-1:0] flag_t;

    typedef enum logic {ST_IDLE, ST_WAIT} ea_state_e;

    function automatic addr_t field_y(input word_t w);
        return w[Y_LSB +: ADDR_W];
    endfunction

    function automatic tag_t field_tag(input word_t w);
        return w[TAG_LSB +: TAG_W];
    endfunction

    function automatic flag_t field_flag(input word_t w);
        return w[FLAG_LSB +: FLAG_W];
    endfunction
endpackage

// File: rtl/ea_index_file.sv
module ea_index_file #(
    parameter int AW = ea_pkg::ADDR_W,
    parameter int TW = ea_pkg::TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lmtm,
    input  logic          ld_en,
    input  logic [TW-1:0] ld_tag,
    input  logic [AW-1:0] ld_data,
    input  logic [TW-1:0] rd_tag,
    output logic [AW-1:0] rd_val
);
    localparam int N = (1 << TW) - 1;

    typedef struct packed {
        logic                grouped;
        logic [N:1][AW-1:0]  regs;
    } file_t;

    file_t file_d, file_q;

    logic [N:1]         ld_hit;
    logic [N:1]         rd_sel;
    logic [N:1][AW-1:0] rd_term;

    for (genvar i = 1; i <= N; i++) begin : g_slot
        localparam bit P2 = ((i & (i - 1)) == 0);
        localparam int BP = P2 ? $clog2(i) : 0;
        assign ld_hit[i]  = file_q.grouped ? (P2 && ld_tag[BP]) : (ld_tag == TW'(i));
        assign rd_sel[i]  = file_q.grouped ? (P2 && rd_tag[BP]) : (rd_tag == TW'(i));
        assign rd_term[i] = rd_sel[i] ? file_q.regs[i] : '0;
    end

    always_comb begin
        rd_val = '0;
        for (int i = 1; i <= N; i++) begin
            rd_val = rd_val | rd_term[i];
        end
    end

    always_comb begin
        file_d = file_q;
        if (lmtm) begin
            file_d.grouped = 1'b0;
        end
        for (int i = 1; i <= N; i++) begin
            if (ld_en && ld_hit[i]) begin
                file_d.regs[i] = ld_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            file_q.grouped <= 1'b1;
            file_q.regs    <= '0;
        end else begin
            file_q <= file_d;
        end
    end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  idx_ctl,
    input  word_t instr,
    input  logic  mem_rvalid,
    input  word_t mem_rdata,
    input  addr_t c_val,
    output tag_t  rd_tag,
    output logic  mem_req,
    output addr_t mem_addr,
    output logic  done,
    output addr_t ea
);
    typedef struct packed {
        ea_state_e state;
        addr_t     ea;
        logic      done;
        addr_t     maddr;
    } seq_t;

    seq_t  seq_d, seq_q;
    word_t src;
    addr_t indexed;

    always_comb begin
        src     = (seq_q.state == ST_WAIT) ? mem_rdata : instr;
        rd_tag  = field_tag(src);
        indexed = field_y(src) - c_val;

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (idx_ctl) begin
                        seq_d.ea   = field_y(instr);
                        seq_d.done = 1'b1;
                    end else if (field_flag(instr) == 2'b11) begin
                        seq_d.maddr = indexed;
                        seq_d.state = ST_WAIT;
                    end else begin
                        seq_d.ea   = indexed;
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    seq_d.ea    = indexed;
                    seq_d.done  = 1'b1;
                    seq_d.state = ST_IDLE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.ea    <= '0;
            seq_q.done  <= 1'b0;
            seq_q.maddr <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_req  = (seq_q.state == ST_WAIT);
    assign mem_addr = seq_q.maddr;
    assign done     = seq_q.done;
    assign ea       = seq_q.ea;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic              idx_ctl,
    input  logic              ld_en,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              lmtm,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea
);
    tag_t  rd_tag;
    addr_t c_val;

    ea_index_file #(.AW(ADDR_W), .TW(TAG_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .lmtm    (lmtm),
        .ld_en   (ld_en),
        .ld_tag  (ld_tag),
        .ld_data (ld_data),
        .rd_tag  (rd_tag),
        .rd_val  (c_val)
    );

    ea_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .idx_ctl    (idx_ctl),
        .instr      (instr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .c_val      (c_val),
        .rd_tag     (rd_tag),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .done       (done),
        .ea         (ea)
    );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
    import ea_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  start,
    input word_t instr,
    input logic  idx_ctl,
    input logic  mem_req,
    input addr_t mem_addr,
    input logic  mem_rvalid,
    input logic  done,
    input addr_t ea
);
    assert_tag0_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !idx_ctl && field_tag(instr) == '0 && field_flag(instr) != 2'b11)
        |=> (done && ea == field_y($past(instr))));

    assert_ctl_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && idx_ctl)
        |=> (done && !mem_req && ea == field_y($past(instr))));

    assert_req_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !idx_ctl && field_flag(instr) == 2'b11)
        |=> (mem_req && !done));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && !done));

    assert_resp_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (done && !mem_req));

    assert_no_stray_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !start) |=> !done);
endmodule

bind ea_unit ea_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .instr      (instr),
    .idx_ctl    (idx_ctl),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .ea         (ea)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, idx_ctl, ld_en, lmtm, mem_rvalid;
    logic [35:0] instr, mem_rdata;
    logic [2:0]  ld_tag;
    logic [14:0] ld_data;
    logic        mem_req, done;
    logic [14:0] mem_addr, ea;

    int checks = 0;
    int errors = 0;

    logic [14:0] mdl_reg [1:7];
    bit          mdl_grouped;
    logic [14:0] exp_q [$];
    string       req_q [$];

    always #2 clk = ~clk;

    ea_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .idx_ctl(idx_ctl),
        .ld_en(ld_en), .ld_tag(ld_tag), .ld_data(ld_data), .lmtm(lmtm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .ea(ea)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] mk(input logic [1:0] f, input logic [2:0] t, input logic [14:0] y);
        logic [35:0] w = '0;
        w[23:22] = f;
        w[17:15] = t;
        w[14:0]  = y;
        return w;
    endfunction

    function automatic logic [14:0] cval(input logic [2:0] t);
        logic [14:0] v = '0;
        if (mdl_grouped) begin
            for (int j = 0; j < 3; j++) if (t[j]) v = v | mdl_reg[1 << j];
        end else if (t != 0) begin
            v = mdl_reg[t];
        end
        return v;
    endfunction

    function automatic void mdl_load(input logic [2:0] t, input logic [14:0] d);
        if (mdl_grouped) begin
            for (int j = 0; j < 3; j++) if (t[j]) mdl_reg[1 << j] = d;
        end else if (t != 0) begin
            mdl_reg[t] = d;
        end
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
                logic [14:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(ea === e, r, "ea", ea, e);
            end
        end
    end

    task automatic load(input logic [2:0] t, input logic [14:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_tag = t; ld_data = d;
        mdl_load(t, d);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic leave_grouped();
        @(negedge clk);
        lmtm = 1'b1;
        mdl_grouped = 1'b0;
        @(negedge clk);
        lmtm = 1'b0;
    endtask

    task automatic issue(input logic [35:0] w, input logic ctl, input string req);
        logic [14:0] e;
        @(negedge clk);
        e = ctl ? w[14:0] : 15'(w[14:0] - cval(w[17:15]));
        exp_q.push_back(e);
        req_q.push_back(req);
        start = 1'b1; instr = w; idx_ctl = ctl;
        @(negedge clk);
        start = 1'b0; idx_ctl = 1'b0;
        check(done === 1'b1, req, "done one cycle after start", done, 1);
        check(mem_req === 1'b0, req, "no request", mem_req, 0);
    endtask

    task automatic indirect(input logic [35:0] w, input logic [35:0] rd, input int waitn,
                            input bit poke, input string req);
        logic [14:0] pa;
        @(negedge clk);
        pa = 15'(w[14:0] - cval(w[17:15]));
        start = 1'b1; instr = w; idx_ctl = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(mem_req === 1'b1, req, "mem_req raised", mem_req, 1);
        check(mem_addr === pa, req, "mem_addr", mem_addr, pa);
        check(done === 1'b0, req, "no done while waiting", done, 0);
        for (int i = 0; i < waitn; i++) begin
            if (poke && i == 0) begin
                start = 1'b1; instr = mk(2'b00, 3'd0, 15'h7777);
            end
            @(negedge clk);
            start = 1'b0;
            check(mem_req === 1'b1 && mem_addr === pa, req, "request held", mem_addr, pa);
        end
        mem_rvalid = 1'b1; mem_rdata = rd;
        exp_q.push_back(15'(rd[14:0] - cval(rd[17:15])));
        req_q.push_back(req);
        @(negedge clk);
        mem_rvalid = 1'b0;
        check(done === 1'b1, req, "done after response", done, 1);
        check(mem_req === 1'b0, req, "request dropped", mem_req, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 0; idx_ctl = 0; ld_en = 0; lmtm = 0; mem_rvalid = 0;
        instr = '0; mem_rdata = '0; ld_tag = '0; ld_data = '0;
        mdl_grouped = 1'b1;
        for (int i = 1; i <= 7; i++) mdl_reg[i] = '0;
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R1", "done in reset", done, 0);
        check(mem_req === 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;

        issue(mk(2'b00, 3'd7, 15'h2345), 1'b0, "R1");      // all registers zero
        issue(mk(2'b00, 3'd0, 15'h1234), 1'b0, "R2");

        load(3'd1, 15'h0010);
        load(3'd2, 15'h0101);
        load(3'd4, 15'h1000);
        issue(mk(2'b00, 3'd1, 15'h2000), 1'b0, "R3");
        issue(mk(2'b00, 3'd3, 15'h2000), 1'b0, "R3");
        issue(mk(2'b00, 3'd7, 15'h3000), 1'b0, "R3");

        load(3'd6, 15'h0200);                               // B and C together
        issue(mk(2'b00, 3'd2, 15'h4000), 1'b0, "R4");
        issue(mk(2'b00, 3'd4, 15'h4000), 1'b0, "R4");
        issue(mk(2'b00, 3'd1, 15'h0005), 1'b0, "R7");      // wraps
        issue(mk(2'b01, 3'd1, 15'h0100), 1'b0, "R10");
        issue(mk(2'b10, 3'd2, 15'h0300), 1'b0, "R10");
        issue(mk(2'b11, 3'd7, 15'h0abc), 1'b1, "R8");

        indirect(mk(2'b11, 3'd1, 15'h0500), mk(2'b11, 3'd2, 15'h0900), 3, 1'b1, "R9");
        indirect(mk(2'b11, 3'd0, 15'h0040), mk(2'b00, 3'd0, 15'h0777), 0, 1'b0, "R9");

        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = mk(2'b00, 3'd0, 15'h1111);
        @(negedge clk);
        mem_rvalid = 1'b0;
        check(done === 1'b0 && mem_req === 1'b0, "R11", "idle response ignored", done, 0);

        // R12: load A in the same cycle as an indexed start
        @(negedge clk);
        exp_q.push_back(15'(15'h3000 - cval(3'd1)));
        req_q.push_back("R12");
        start = 1'b1; instr = mk(2'b00, 3'd1, 15'h3000);
        ld_en = 1'b1; ld_tag = 3'd1; ld_data = 15'h0444;
        mdl_load(3'd1, 15'h0444);
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        check(done === 1'b1, "R12", "done", done, 1);
        issue(mk(2'b00, 3'd1, 15'h3000), 1'b0, "R12");

        leave_grouped();
        issue(mk(2'b00, 3'd3, 15'h0600), 1'b0, "R6");      // reg 3 never written
        issue(mk(2'b00, 3'd5, 15'h0600), 1'b0, "R6");
        load(3'd3, 15'h0033);
        issue(mk(2'b00, 3'd3, 15'h0600), 1'b0, "R5");
        issue(mk(2'b00, 3'd1, 15'h0600), 1'b0, "R5");      // A untouched
        load(3'd7, 15'h0077);
        issue(mk(2'b00, 3'd7, 15'h0600), 1'b0, "R5");
        indirect(mk(2'b11, 3'd3, 15'h0100), mk(2'b11, 3'd7, 15'h0800), 2, 1'b0, "R5");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule